// File: doc/BRIEF.md
# Cascadable Timer with Slave and Master Mode Control

This block is a counter timer built to sit in a chain of timers. Its slave mode decides how an external trigger input or a pair of quadrature inputs acts on the counter. The trigger can start the counter, gate it, reinitialise it or clock it, and the quadrature pair can count it up or down. Its master mode picks the internal event that drives the trigger output. That output can feed the trigger input of a downstream timer or start a converter. Four compare reference outputs are high while the counter sits below their thresholds.

Software writes the configuration one word at a time through a simple write port: a control word, a prescaler, an auto-reload value, a software update command and four compare thresholds. The prescaler and auto-reload values pass through shadow registers. A software update command or any update event loads them. The counter value is brought out so that the chain above it can observe it.

Top module: `cascade_timer`

## Requirements
- R1: After reset the counter is 0, the control word, prescaler, auto-reload and compare registers are 0, the timer is disabled, trig_out is 0 and cmp_ref is 4'b0000.
- R2: Write addresses are: 0 control word (bit 0 enable, bit 1 auto-reload preload, bit 2 count down, bits 6:4 slave mode, bits 10:8 master mode); 1 prescaler; 2 auto-reload; 3 command (bit 0 = software update); 4 to 7 compare thresholds 1 to 4. A write takes effect at the clock edge on which wr_en is sampled high.
- R3: In slave mode 0 the prescaler runs on the internal clock while the timer is enabled. With prescaler value P the counter steps once every P+1 clocks. While the timer is disabled the counter holds its value.
- R4: Counting up, a step taken at or above the active auto-reload value wraps to 0. Counting down, a step taken at 0 reloads the active auto-reload value. Each wrap is an update event lasting one clock.
- R5: When preload is set, the active auto-reload is a shadow copy that loads only on an update event. When preload is clear, a written value takes effect at once. The software update command loads the prescaler and auto-reload shadows and reinitialises the counter (0 counting up, the written auto-reload counting down), and it is itself an update event.
- R6: Encoder modes 1, 2 and 3 step once per edge: of input B only, of input A only, or of exactly one of the two inputs. A B edge counts up when B's new level equals A's level. An A edge counts up when A's new level differs from B's level. Otherwise the step counts down. Encoder steps bypass the prescaler and need the enable bit.
- R7: In slave mode 4, a rising trigger edge reinitialises the counter and the prescaler as the software update command does, and it is an update event that loads the shadows.
- R8: In slave mode 5 the prescaler is clocked only while the synchronised trigger is high. While it is low the counter holds its value and is not cleared.
- R9: In slave mode 6 a rising trigger edge sets the enable bit without changing the counter, and counting starts on the following clock.
- R10: In slave mode 7 each rising trigger edge, when enabled, clocks the prescaler, and no other event advances the counter.
- R11: Master mode selects trig_out. 0: a one-clock pulse on the software update command or on a mode-4 trigger reset. 1: the enable bit. 2: a one-clock pulse per update event. 3: a one-clock pulse when a count step brings the counter to compare threshold 1. 4 to 7: compare references 1 to 4.
- R12: cmp_ref[i] is high while the counter is below compare threshold i+1.
- R13: An edge on trig_in, enc_a or enc_b first acts at the third rising clock edge after the input changes (two synchroniser flops, then an edge register).

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W (16) | Write data |
| trig_in | input | 1 | Trigger input from an upstream timer |
| enc_a | input | 1 | Quadrature input A |
| enc_b | input | 1 | Quadrature input B |
| trig_out | output | 1 | Trigger output to downstream timers |
| cmp_ref | output | 4 | Compare reference outputs 1 to 4 |
| cnt_o | output | CNT_W (16) | Current counter value |

## Verification
The assertions watch rules that hold on every cycle. The counter never moves by more than one step except on an update event. It holds while disabled, while a gated trigger is low, between external clock edges and between encoder edges. A start trigger always sets the enable bit, a reset trigger always yields an update event, and a channel-1 compare pulse always matches the threshold. Only the bench scenarios can show the exact values: the prescaler divide ratio, the wrap points up and down, the shadow timing of the auto-reload, the quadrature direction sequence, the three-edge input latency and the source chosen for each master mode.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [2:0] {
      SLV_OFF    = 3'd0,
      SLV_ENC_B  = 3'd1,
      SLV_ENC_A  = 3'd2,
      SLV_ENC_AB = 3'd3,
      SLV_RESET  = 3'd4,
      SLV_GATED  = 3'd5,
      SLV_START  = 3'd6,
      SLV_EXTCLK = 3'd7
   } slv_mode_e;

   typedef enum logic [2:0] {
      MST_SWUPD  = 3'd0,
      MST_ENABLE = 3'd1,
      MST_UPDATE = 3'd2,
      MST_CC1    = 3'd3,
      MST_REF1   = 3'd4,
      MST_REF2   = 3'd5,
      MST_REF3   = 3'd6,
      MST_REF4   = 3'd7
   } mst_mode_e;

   localparam int ADDR_W  = 3;
   localparam int NUM_REF = 4;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_PSC   = 3'd1;
   localparam logic [ADDR_W-1:0] A_ARR   = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMD   = 3'd3;
   localparam logic [ADDR_W-1:0] A_CMP0  = 3'd4;
   localparam int B_EN  = 0;
   localparam int B_PRE = 1;
   localparam int B_DIR = 2;
   localparam int B_SLV = 4;
   localparam int B_MST = 8;
   localparam int CTRL_MSB = B_MST + 2;
endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic chg
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign lvl = sh[STAGES-1];
   assign chg = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [CNT_W-1:0]               wr_data,
   input  logic                           start_set,
   output logic                           en,
   output logic                           pre,
   output logic                           dir_dn,
   output slv_mode_e                      slv,
   output mst_mode_e                      mst,
   output logic [CNT_W-1:0]               psc_reg,
   output logic [CNT_W-1:0]               arr_reg,
   output logic [NUM_REF-1:0][CNT_W-1:0]  cmp_val,
   output logic                           ug
);
   logic wr_ctrl;
   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign ug      = wr_en && (wr_addr == A_CMD) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         pre     <= 1'b0;
         dir_dn  <= 1'b0;
         slv     <= SLV_OFF;
         mst     <= MST_SWUPD;
         psc_reg <= '0;
         arr_reg <= '0;
      end else begin
         if (wr_ctrl) begin
            en     <= wr_data[B_EN];
            pre    <= wr_data[B_PRE];
            dir_dn <= wr_data[B_DIR];
            slv    <= slv_mode_e'(wr_data[B_SLV +: 3]);
            mst    <= mst_mode_e'(wr_data[B_MST +: 3]);
         end
         if (start_set) en <= 1'b1;
         if (wr_en && wr_addr == A_PSC) psc_reg <= wr_data;
         if (wr_en && wr_addr == A_ARR) arr_reg <= wr_data;
      end
   end

   for (genvar i = 0; i < NUM_REF; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ADDR = A_CMP0 + ADDR_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           cmp_val[i] <= '0;
         else if (wr_en && wr_addr == MY_ADDR) cmp_val[i] <= wr_data;
      end
   end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pre,
   input  logic             dir_dn,
   input  slv_mode_e        slv,
   input  logic [CNT_W-1:0] psc_reg,
   input  logic [CNT_W-1:0] arr_reg,
   input  logic [CNT_W-1:0] cmp1,
   input  logic             ug,
   input  logic             trig_lvl,
   input  logic             trig_chg,
   input  logic             a_lvl,
   input  logic             a_chg,
   input  logic             b_lvl,
   input  logic             b_chg,
   output logic [CNT_W-1:0] cnt,
   output logic             ev_upd,
   output logic             ev_rst,
   output logic             ev_cc1
);
   logic [CNT_W-1:0] psc_sh, arr_sh, psc_cnt, arr_act, cnt_nxt;
   logic trig_rise, enc_mode, tick, psc_hit, enc_step, enc_up;
   logic step, up, wrap, reload, upd;

   assign trig_rise = trig_lvl & trig_chg;
   assign enc_mode  = (slv == SLV_ENC_B) || (slv == SLV_ENC_A) || (slv == SLV_ENC_AB);

   // prescaler clock source per slave mode
   always_comb begin
      case (slv)
         SLV_GATED:  tick = en & trig_lvl;
         SLV_EXTCLK: tick = en & trig_rise;
         SLV_ENC_B, SLV_ENC_A, SLV_ENC_AB: tick = 1'b0;
         default:    tick = en;
      endcase
   end

   // quadrature decode: direction from new level versus the other input
   always_comb begin
      enc_step = 1'b0;
      enc_up   = 1'b0;
      case (slv)
         SLV_ENC_B: begin
            enc_step = b_chg;
            enc_up   = (b_lvl == a_lvl);
         end
         SLV_ENC_A: begin
            enc_step = a_chg;
            enc_up   = (a_lvl != b_lvl);
         end
         SLV_ENC_AB: begin
            enc_step = a_chg ^ b_chg;
            enc_up   = a_chg ? (a_lvl != b_lvl) : (b_lvl == a_lvl);
         end
         default: ;
      endcase
   end

   assign psc_hit = (psc_cnt == psc_sh);
   assign step    = enc_mode ? (en & enc_step) : (tick & psc_hit);
   assign up      = enc_mode ? enc_up : ~dir_dn;
   assign reload  = ug | ((slv == SLV_RESET) & trig_rise);
   assign arr_act = pre ? arr_sh : arr_reg;
   assign wrap    = up ? (cnt >= arr_act) : (cnt == '0);
   assign upd     = reload | (step & wrap);

   always_comb begin
      if (reload)      cnt_nxt = dir_dn ? arr_reg : '0;
      else if (!step)  cnt_nxt = cnt;
      else if (up)     cnt_nxt = wrap ? '0 : cnt + 1'b1;
      else             cnt_nxt = wrap ? arr_act : cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         psc_cnt <= '0;
         psc_sh  <= '0;
         arr_sh  <= '0;
         ev_upd  <= 1'b0;
         ev_rst  <= 1'b0;
         ev_cc1  <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         if (reload)    psc_cnt <= '0;
         else if (tick) psc_cnt <= psc_hit ? '0 : psc_cnt + 1'b1;
         if (upd) begin
            psc_sh <= psc_reg;
            arr_sh <= arr_reg;
         end
         ev_upd <= upd;
         ev_rst <= reload;
         ev_cc1 <= step & ~reload & (cnt_nxt == cmp1);
      end
   end
endmodule

// File: rtl/tmr_trgo_sel.sv
`timescale 1ns/1ps
module tmr_trgo_sel
   import tmr_pkg::*;
(
   input  mst_mode_e          mst,
   input  logic               ev_rst,
   input  logic               en,
   input  logic               ev_upd,
   input  logic               ev_cc1,
   input  logic [NUM_REF-1:0] refs,
   output logic               trgo
);
   logic [2:0] m;
   assign m = mst;

   always_comb begin
      case (mst)
         MST_SWUPD:  trgo = ev_rst;
         MST_ENABLE: trgo = en;
         MST_UPDATE: trgo = ev_upd;
         MST_CC1:    trgo = ev_cc1;
         default:    trgo = refs[m[1:0]];
      endcase
   end
endmodule

// File: rtl/cascade_timer.sv
`timescale 1ns/1ps
module cascade_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic               trig_in,
   input  logic               enc_a,
   input  logic               enc_b,
   output logic               trig_out,
   output logic [3:0]         cmp_ref,
   output logic [CNT_W-1:0]   cnt_o
);
   localparam int NUM_IN = 3;

   if (CNT_W < CTRL_MSB + 1 || CNT_W > 32) begin : g_bad_width
      $error("cascade_timer: CNT_W must lie between 11 and 32");
   end

   logic [NUM_IN-1:0] raw_in, in_lvl, in_chg;
   assign raw_in = {enc_b, enc_a, trig_in};

   for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
      tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_in[g]),
         .lvl  (in_lvl[g]),
         .chg  (in_chg[g])
      );
   end

   logic trig_lvl, trig_chg, trig_rise;
   assign trig_lvl  = in_lvl[0];
   assign trig_chg  = in_chg[0];
   assign trig_rise = trig_lvl & trig_chg;

   logic en_q, pre_q, dir_q, ug_pulse, ev_upd_q, ev_rst_q, ev_cc1_q;
   slv_mode_e slv_mode;
   mst_mode_e mst_mode;
   logic [CNT_W-1:0] psc_reg, arr_reg;
   logic [NUM_REF-1:0][CNT_W-1:0] cmp_val;

   tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .start_set((slv_mode == SLV_START) & trig_rise),
      .en       (en_q),
      .pre      (pre_q),
      .dir_dn   (dir_q),
      .slv      (slv_mode),
      .mst      (mst_mode),
      .psc_reg  (psc_reg),
      .arr_reg  (arr_reg),
      .cmp_val  (cmp_val),
      .ug       (ug_pulse)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .pre     (pre_q),
      .dir_dn  (dir_q),
      .slv     (slv_mode),
      .psc_reg (psc_reg),
      .arr_reg (arr_reg),
      .cmp1    (cmp_val[0]),
      .ug      (ug_pulse),
      .trig_lvl(trig_lvl),
      .trig_chg(trig_chg),
      .a_lvl   (in_lvl[1]),
      .a_chg   (in_chg[1]),
      .b_lvl   (in_lvl[2]),
      .b_chg   (in_chg[2]),
      .cnt     (cnt_o),
      .ev_upd  (ev_upd_q),
      .ev_rst  (ev_rst_q),
      .ev_cc1  (ev_cc1_q)
   );

   for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
      assign cmp_ref[i] = (cnt_o < cmp_val[i]);
   end

   tmr_trgo_sel u_trgo (
      .mst   (mst_mode),
      .ev_rst(ev_rst_q),
      .en    (en_q),
      .ev_upd(ev_upd_q),
      .ev_cc1(ev_cc1_q),
      .refs  (cmp_ref),
      .trgo  (trig_out)
   );
endmodule

// File: rtl/cascade_timer_chk.sv
`timescale 1ns/1ps
module cascade_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             en,
   input logic [2:0]       slv,
   input logic             ug,
   input logic             trig_lvl,
   input logic             trig_rise,
   input logic             a_chg,
   input logic             b_chg,
   input logic             ev_upd,
   input logic             ev_cc1,
   input logic [CNT_W-1:0] cmp1
);
   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_upd |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

   assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ug && !(slv == 3'd4 && trig_rise)) |=> $stable(cnt));

   assert_gate_low_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slv == 3'd5 && !trig_lvl && !ug) |=> $stable(cnt));

   assert_start_sets_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (slv == 3'd6 && trig_rise) |=> en);

   assert_ext_edge_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slv == 3'd7 && !trig_rise && !ug) |=> $stable(cnt));

   assert_enc_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slv >= 3'd1 && slv <= 3'd3 && !a_chg && !b_chg && !ug) |=> $stable(cnt));

   assert_reset_is_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slv == 3'd4 && trig_rise) |=> ev_upd);

   assert_cc1_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cc1 |-> (cnt == $past(cmp1)));
endmodule

bind cascade_timer cascade_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (cnt_o),
   .en       (en_q),
   .slv      (slv_mode),
   .ug       (ug_pulse),
   .trig_lvl (trig_lvl),
   .trig_rise(trig_rise),
   .a_chg    (in_chg[1]),
   .b_chg    (in_chg[2]),
   .ev_upd   (ev_upd_q),
   .ev_cc1   (ev_cc1_q),
   .cmp1     (cmp_val[0])
);

// File: tb/tb_cascade_timer.sv
`timescale 1ns/1ps
module tb_cascade_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        trig_in = 1'b0;
   logic        enc_a = 1'b0;
   logic        enc_b = 1'b0;
   logic        trig_out;
   logic [3:0]  cmp_ref;
   logic [15:0] cnt_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cascade_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_in(trig_in), .enc_a(enc_a), .enc_b(enc_b),
      .trig_out(trig_out), .cmp_ref(cmp_ref), .cnt_o(cnt_o)
   );

   // quadrature walk in encoder mode 3: {a, b, expected count}
   localparam logic [17:0] ENC_VEC [9] = '{
      {1'b1, 1'b0, 16'd1},   {1'b1, 1'b1, 16'd2},   {1'b0, 1'b1, 16'd3},
      {1'b0, 1'b0, 16'd4},   {1'b0, 1'b1, 16'd3},   {1'b1, 1'b1, 16'd2},
      {1'b1, 1'b0, 16'd1},   {1'b0, 1'b0, 16'd0},   {1'b0, 1'b1, 16'd100}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] addr, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_ctrl(input bit en, input bit pre, input bit dn,
                           input logic [2:0] slv, input logic [2:0] mst);
      wr(3'd0, {5'd0, mst, 1'b0, slv, 1'b0, dn, pre, en});
   endtask

   task automatic restart(input logic [15:0] psc, input logic [15:0] arr);
      trig_in = 1'b0; enc_a = 1'b0; enc_b = 1'b0;
      set_ctrl(0, 1, 0, 3'd0, 3'd0);
      wait_n(4);
      wr(3'd1, psc);
      wr(3'd2, arr);
      wr(3'd3, 16'd1);
   endtask

   task automatic trig_pulse();
      trig_in = 1'b1; wait_n(4);
      trig_in = 1'b0; wait_n(4);
   endtask

   task automatic quad_forward();
      enc_a = 1'b1; wait_n(4);
      enc_b = 1'b1; wait_n(4);
      enc_a = 1'b0; wait_n(4);
      enc_b = 1'b0; wait_n(4);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      check("R1 counter after reset", cnt_o, 0);
      check("R1 trig_out after reset", trig_out, 0);
      check("R1 cmp_ref after reset", cmp_ref, 0);

      // R3 / R4: free-running up count, reload 4
      restart(16'd0, 16'd4);
      set_ctrl(1, 1, 0, 3'd0, 3'd2);
      check("R2 control write lands, no step yet", cnt_o, 0);
      wait_n(3);
      check("R3 internal clock count", cnt_o, 3);
      wait_n(2);
      check("R4 wrap to zero counting up", cnt_o, 0);
      check("R4 update pulse on wrap", trig_out, 1);
      wait_n(1);
      check("R4 update lasts one clock", trig_out, 0);
      set_ctrl(0, 1, 0, 3'd0, 3'd2);
      held = cnt_o;
      wait_n(5);
      check("R3 disabled counter holds", cnt_o, held);

      // R3: prescaler divide by 3
      restart(16'd2, 16'd100);
      set_ctrl(1, 1, 0, 3'd0, 3'd2);
      wait_n(5);
      check("R3 prescaler first step", cnt_o, 1);
      wait_n(1);
      check("R3 prescaler second step", cnt_o, 2);

      // R11 master 0: software update pulse
      set_ctrl(0, 1, 0, 3'd0, 3'd0);
      wr(3'd3, 16'd1);
      check("R11 master 0 pulse on update command", trig_out, 1);
      check("R5 update command clears counter", cnt_o, 0);
      wait_n(1);
      check("R11 master 0 pulse ends", trig_out, 0);

      // R5: preload keeps old reload until update
      restart(16'd0, 16'd100);
      wr(3'd2, 16'd3);
      set_ctrl(1, 1, 0, 3'd0, 3'd2);
      wait_n(6);
      check("R5 preloaded reload not yet active", cnt_o, 6);
      wr(3'd3, 16'd1);
      check("R5 update command reinitialises", cnt_o, 0);
      wait_n(3);
      check("R5 count below new reload", cnt_o, 3);
      wait_n(1);
      check("R5 new reload active after update", cnt_o, 0);
      restart(16'd0, 16'd100);
      set_ctrl(0, 0, 0, 3'd0, 3'd2);
      wr(3'd2, 16'd2);
      set_ctrl(1, 0, 0, 3'd0, 3'd2);
      wait_n(3);
      check("R5 no preload takes effect at once", cnt_o, 0);

      // R4: down counting
      restart(16'd0, 16'd3);
      set_ctrl(0, 1, 1, 3'd0, 3'd2);
      wr(3'd3, 16'd1);
      check("R4 update command counting down loads reload", cnt_o, 3);
      set_ctrl(1, 1, 1, 3'd0, 3'd2);
      wait_n(3);
      check("R4 down count reaches zero", cnt_o, 0);
      wait_n(1);
      check("R4 down wrap reloads", cnt_o, 3);
      check("R4 down wrap update pulse", trig_out, 1);

      // R10 / R12 / R11: external clock and compare
      restart(16'd0, 16'd100);
      set_ctrl(1, 1, 0, 3'd7, 3'd3);
      wr(3'd4, 16'd5);
      wr(3'd5, 16'd3);
      wr(3'd6, 16'd0);
      wr(3'd7, 16'hFFFF);
      wait_n(4);
      check("R10 no trigger edge no count", cnt_o, 0);
      for (int k = 0; k < 4; k++) trig_pulse();
      check("R10 four trigger edges", cnt_o, 4);
      check("R12 compare references at 4", cmp_ref, 4'b1001);
      trig_in = 1'b1;
      wait_n(2);
      check("R13 no action before third edge", cnt_o, 4);
      wait_n(1);
      check("R13 edge acts on third clock", cnt_o, 5);
      check("R11 master 3 compare pulse", trig_out, 1);
      wait_n(1);
      check("R11 master 3 pulse ends", trig_out, 0);
      trig_in = 1'b0;
      wait_n(4);
      check("R12 compare references at 5", cmp_ref, 4'b1000);
      set_ctrl(1, 1, 0, 3'd7, 3'd4);
      check("R11 master 4 follows reference 1", trig_out, 0);
      set_ctrl(1, 1, 0, 3'd7, 3'd7);
      check("R11 master 7 follows reference 4", trig_out, 1);

      // R8: gated
      restart(16'd0, 16'd100);
      set_ctrl(1, 1, 0, 3'd5, 3'd1);
      wait_n(4);
      check("R8 gate low no count", cnt_o, 0);
      trig_in = 1'b1;
      wait_n(10);
      trig_in = 1'b0;
      wait_n(6);
      check("R8 counts only while gate high", cnt_o, 10);
      wait_n(5);
      check("R8 holds value after gate low", cnt_o, 10);

      // R9: trigger start
      set_ctrl(0, 1, 0, 3'd6, 3'd1);
      check("R11 master 1 shows disabled", trig_out, 0);
      wait_n(3);
      check("R9 waits for trigger", cnt_o, 10);
      trig_in = 1'b1;
      wait_n(6);
      check("R9 start without reset", cnt_o, 13);
      check("R9 enable set by trigger", trig_out, 1);
      trig_in = 1'b0;
      wait_n(4);

      // R7: reset mode
      restart(16'd0, 16'd100);
      wr(3'd2, 16'd7);
      set_ctrl(1, 1, 0, 3'd4, 3'd0);
      wait_n(5);
      trig_in = 1'b1;
      wait_n(3);
      check("R7 trigger reinitialises counter", cnt_o, 0);
      check("R7 master 0 pulse on trigger reset", trig_out, 1);
      trig_in = 1'b0;
      wait_n(7);
      check("R7 counting after reset", cnt_o, 7);
      wait_n(1);
      check("R7 reset loaded reload shadow", cnt_o, 0);

      // R6: quadrature table, mode 3
      restart(16'd0, 16'd100);
      set_ctrl(1, 1, 0, 3'd3, 3'd2);
      for (int i = 0; i < 9; i++) begin
         enc_a = ENC_VEC[i][17];
         enc_b = ENC_VEC[i][16];
         wait_n(4);
         check($sformatf("R6 encoder mode 3 step %0d", i), cnt_o, ENC_VEC[i][15:0]);
      end

      restart(16'd0, 16'd100);
      set_ctrl(1, 1, 0, 3'd1, 3'd2);
      quad_forward();
      check("R6 encoder mode 1 counts B edges", cnt_o, 2);
      restart(16'd0, 16'd100);
      set_ctrl(1, 1, 0, 3'd2, 3'd2);
      quad_forward();
      check("R6 encoder mode 2 counts A edges", cnt_o, 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule